// File: doc/BRIEF.md
# Cascaded PDM Clock Generator

This block turns a fast source clock into the timing set for a PDM microphone front end. All of it stays in one clock domain. Three dividers are chained. The first takes the source down to the core rate. The second takes the core rate down to an intermediate rate. The third takes that rate down to the microphone clock. Each divided rate is carried as a one-cycle enable pulse or a level that is registered against the source clock, never as a derived clock net. A programmable offset then places a data-sampling strobe a few core periods before or after each rising edge of the microphone clock.

The enable input starts and stops the whole chain. While it is low, every counter is held cleared. After it rises, the microphone clock stays low for one full output period and then runs. A third-divider value of zero is a forbidden setting. The block reports it on an error flag and keeps the clock output quiet.

The block carries no data stream, so there is no valid/ready handshake. All pins are plain control and status signals that are sampled or driven on every source clock.

Top module: `pdmclk_gen`

## Requirements
- R1: While `enable` is low, `core_ce`, `cko_level`, `cko_rise`, `smp_strobe` and `cfg_err` are all low, and the next enable restarts every counter from zero.
- R2: `core_ce` pulses once every D1 source cycles, where D1 = `div1_code` + 1 (code 0..3 gives ratio 1..4). The first pulse comes in the first enabled cycle.
- R3: With `div3_n` = N > 0, successive CKO rising edges are D1 * D2 * (N + 1) source cycles apart, where D2 = `div2_code` + 1 (code 0..3 gives ratio 1..4).
- R4: Each CKO period starts with a high phase of floor((N + 1) / 2) intermediate-rate periods, that is floor((N+1)/2) * D2 * D1 source cycles. The low phase fills the rest of the period.
- R5: The first CKO rising edge comes exactly D1 * D2 * (N + 1) source cycles after the first enabled cycle. Before that, `cko_level` stays low.
- R6: `cko_rise` is high for exactly the one source cycle in which `cko_level` goes high. That cycle also carries a `core_ce` pulse.
- R7: Delay code c (0..7) gives a signed offset of c - 3 core periods, so the range runs from 3 early to 4 late. `smp_strobe` pulses with `core_ce` once per CKO period, at the core period whose index within the CKO period (index 0 is the one where the rising edge falls) equals that offset taken modulo the period length in core periods, D2 * (N + 1).
- R8: `smp_strobe` stays low until the first full CKO period after enable has elapsed. Its first pulse comes (P + S) * D1 source cycles after the first enabled cycle, where P = D2 * (N + 1) and S is the modulo slot of R7.
- R9: When `div3_n` is 0 and `enable` is high, `cfg_err` is high and `cko_level`, `cko_rise` and `smp_strobe` stay low. `core_ce` keeps running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the divider chain; low holds all counters cleared |
| div1_code | input | 2 | First divider code, ratio = code + 1 |
| div2_code | input | 2 | Second divider code, ratio = code + 1 |
| div3_n | input | DIV3_W (8) | Third divider value N, ratio = N + 1, zero forbidden |
| smp_dly_code | input | 3 | Sampler offset code, offset = code - 3 core periods |
| core_ce | output | 1 | One-cycle pulse at the start of each core period |
| cko_level | output | 1 | Microphone clock output level |
| cko_rise | output | 1 | One-cycle marker of the CKO rising edge |
| smp_strobe | output | 1 | One-cycle data-sampling strobe |
| cfg_err | output | 1 | Forbidden third-divider value while enabled |

## Verification
If a prescaler counter goes wrong, the spacing of `core_ce` pulses is off from the next core period onward, and every CKO edge after that is displaced by a whole number of core periods. A period counter that drifts out of step with the third divider shows up within one CKO period, as a strobe whose distance from `cko_rise` no longer matches the programmed offset. If the start-up flag is set too early, a rising edge or a strobe appears inside the first output period. If the flag is never set, `cko_level` stays flat. Stimulus sweeps the modulo wrap cases where the offset exceeds a short period, runs the forbidden value, and restarts after a disable, because each of these puts state errors on the pins within one or two periods.

// File: rtl/pdmclk_pkg.sv
package pdmclk_pkg;

  typedef logic [1:0] pre_code_t;
  typedef logic [2:0] dly_code_t;

  // Ratio of a 2-bit prescaler code: code 0..3 divides by 1..4.
  function automatic logic [2:0] pre_ratio(input pre_code_t code);
    return {1'b0, code} + 3'd1;
  endfunction

  // Sampler offset in core periods: code 0..7 maps to -3..+4.
  function automatic logic signed [3:0] smp_offset(input dly_code_t code);
    return $signed({1'b0, code}) - 4'sd3;
  endfunction

endpackage

// File: rtl/pdmclk_wrapcnt.sv
module pdmclk_wrapcnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         wrap
);

  // Wraps at or beyond the limit so a limit lowered mid-count cannot run away.
  assign wrap = adv && (count >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (adv) begin
      count <= wrap ? '0 : count + W'(1);
    end
  end

endmodule

// File: rtl/pdmclk_sampler.sv
module pdmclk_sampler
  import pdmclk_pkg::*;
#(
  parameter int DIV3_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              core_tick,
  input  logic              period_wrap,
  input  logic              core_first,
  input  logic              armed,
  input  logic              err,
  input  pre_code_t         div2_code,
  input  logic [DIV3_W-1:0] div3_n,
  input  dly_code_t         dly_code,
  output logic              strobe
);

  localparam int PW  = DIV3_W + 2;
  localparam int NRM = 4;

  logic [PW-1:0]        pos;
  logic [DIV3_W:0]      n_ratio;
  logic [PW:0]          period;
  logic signed [PW+1:0] period_s;
  logic signed [PW+1:0] slot_v;
  logic [PW-1:0]        slot;

  // Core-period index inside the current CKO period, realigned on every wrap.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (clr || period_wrap) begin
      pos <= '0;
    end else if (core_tick) begin
      pos <= pos + PW'(1);
    end
  end

  assign n_ratio  = {1'b0, div3_n} + (DIV3_W+1)'(1);
  assign period   = (PW+1)'(pre_ratio(div2_code)) * (PW+1)'(n_ratio);
  assign period_s = $signed({1'b0, period});

  // Offset modulo the period; a period of two needs two folds either way.
  always_comb begin
    slot_v = (PW+2)'(smp_offset(dly_code));
    for (int i = 0; i < NRM; i++) begin
      if (slot_v < 0) slot_v = slot_v + period_s;
    end
    for (int i = 0; i < NRM; i++) begin
      if (slot_v >= period_s) slot_v = slot_v - period_s;
    end
    slot = PW'(unsigned'(slot_v));
  end

  assign strobe = core_first && armed && !err && (pos == slot);

endmodule

// File: rtl/pdmclk_gen.sv
module pdmclk_gen
  import pdmclk_pkg::*;
#(
  parameter int DIV3_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        div1_code,
  input  logic [1:0]        div2_code,
  input  logic [DIV3_W-1:0] div3_n,
  input  logic [2:0]        smp_dly_code,
  output logic              core_ce,
  output logic              cko_level,
  output logic              cko_rise,
  output logic              smp_strobe,
  output logic              cfg_err
);

  localparam int NSTG = 2;

  pre_code_t         pre_lim  [NSTG];
  pre_code_t         pre_cnt  [NSTG];
  logic              pre_tick [NSTG+1];
  logic [DIV3_W-1:0] n_cnt;
  logic              cko_wrap;
  logic [DIV3_W:0]   hi_len;
  logic              core_first;
  logic              armed;

  assign pre_lim[0]  = div1_code;
  assign pre_lim[1]  = div2_code;
  assign pre_tick[0] = enable;

  // Stage 0 yields the core rate, stage 1 the intermediate rate.
  generate
    for (genvar g = 0; g < NSTG; g++) begin : g_pre
      pdmclk_wrapcnt #(.W(2)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (~enable),
        .adv   (pre_tick[g]),
        .limit (pre_lim[g]),
        .count (pre_cnt[g]),
        .wrap  (pre_tick[g+1])
      );
    end
  endgenerate

  pdmclk_wrapcnt #(.W(DIV3_W)) u_div3 (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (~enable),
    .adv   (pre_tick[NSTG]),
    .limit (div3_n),
    .count (n_cnt),
    .wrap  (cko_wrap)
  );

  // Output is suppressed until one full CKO period has passed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (!enable) begin
      armed <= 1'b0;
    end else if (cko_wrap) begin
      armed <= 1'b1;
    end
  end

  assign core_first = enable && (pre_cnt[0] == 2'd0);
  assign hi_len     = ({1'b0, div3_n} + (DIV3_W+1)'(1)) >> 1;

  assign cfg_err   = enable && (div3_n == '0);
  assign core_ce   = core_first;
  assign cko_level = enable && armed && !cfg_err && ({1'b0, n_cnt} < hi_len);
  assign cko_rise  = core_first && armed && !cfg_err &&
                     (n_cnt == '0) && (pre_cnt[1] == 2'd0);

  pdmclk_sampler #(.DIV3_W(DIV3_W)) u_smp (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (~enable),
    .core_tick   (pre_tick[1]),
    .period_wrap (cko_wrap),
    .core_first  (core_first),
    .armed       (armed),
    .err         (cfg_err),
    .div2_code   (div2_code),
    .div3_n      (div3_n),
    .dly_code    (smp_dly_code),
    .strobe      (smp_strobe)
  );

endmodule

// File: rtl/pdmclk_gen_chk.sv
module pdmclk_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic [1:0] div1_code,
  input logic       core_ce,
  input logic       cko_level,
  input logic       cko_rise,
  input logic       smp_strobe,
  input logic       cfg_err
);

  assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !(core_ce || cko_level || cko_rise || smp_strobe || cfg_err));

  assert_unit_ratio_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enable && (div1_code == 2'd0) && $stable(div1_code) |-> core_ce);

  assert_quiet_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> !cko_level && !cko_rise && !smp_strobe);

  assert_rise_on_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cko_rise |-> cko_level && core_ce);

  assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cko_rise |=> !cko_rise);

  assert_strobe_on_core_R7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_strobe |-> core_ce);

  assert_err_silences_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !cko_level && !cko_rise && !smp_strobe);

endmodule

bind pdmclk_gen pdmclk_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .div1_code  (div1_code),
  .core_ce    (core_ce),
  .cko_level  (cko_level),
  .cko_rise   (cko_rise),
  .smp_strobe (smp_strobe),
  .cfg_err    (cfg_err)
);

// File: tb/test_pdmclk_gen.sv
module test_pdmclk_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] div1_code = 2'd0;
  logic [1:0] div2_code = 2'd0;
  logic [7:0] div3_n = 8'd1;
  logic [2:0] smp_dly_code = 3'd3;
  logic       core_ce, cko_level, cko_rise, smp_strobe, cfg_err;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pdmclk_gen #(.DIV3_W(8)) i_pdmclk_gen (
    .clk (clk), .rst_n (rst_n), .enable (enable),
    .div1_code (div1_code), .div2_code (div2_code), .div3_n (div3_n),
    .smp_dly_code (smp_dly_code),
    .core_ce (core_ce), .cko_level (cko_level), .cko_rise (cko_rise),
    .smp_strobe (smp_strobe), .cfg_err (cfg_err)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic string sig_tag(input int i);
    case (i)
      0: return "R2 core_ce";
      1: return "R4 cko_level";
      2: return "R6 cko_rise";
      3: return "R7 smp_strobe";
      default: return "R9 cfg_err";
    endcase
  endfunction

  // R1: all outputs low while enable is low
  task automatic t_idle(input string name);
    @(negedge clk);
    enable = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1;
      check({core_ce, cko_level, cko_rise, smp_strobe, cfg_err} == 5'b0,
            {"R1 idle outputs ", name},
            int'({core_ce, cko_level, cko_rise, smp_strobe, cfg_err}), 0);
      @(negedge clk);
    end
  endtask

  // Runs three CKO periods from a fresh enable and compares every cycle.
  task automatic t_sweep(input int d1c, input int d2c, input int n, input int dly,
                         input string name);
    int d1, d2, per, hi, off, slot, ncyc, k, ph;
    int mis[5], fa[5], fe[5];
    int first_rise, second_rise, first_stb, nrise, nstb;
    bit err, first, arm;
    bit [4:0] act, exp;
    d1 = d1c + 1;
    d2 = d2c + 1;
    per = d2 * (n + 1);
    hi = (n + 1) / 2;
    off = dly - 3;
    slot = ((off % per) + per) % per;
    err = (n == 0);
    ncyc = 3 * per * d1 + 4;
    first_rise = -1; second_rise = -1; first_stb = -1; nrise = 0; nstb = 0;
    for (int i = 0; i < 5; i++) begin mis[i] = 0; fa[i] = 0; fe[i] = 0; end
    @(negedge clk);
    enable = 1'b0;
    div1_code = 2'(d1c); div2_code = 2'(d2c); div3_n = 8'(n); smp_dly_code = 3'(dly);
    repeat (2) @(negedge clk);
    enable = 1'b1;
    for (int t = 0; t < ncyc; t++) begin
      #1;
      k = t / d1;
      first = (t % d1) == 0;
      arm = k >= per;
      ph = k % per;
      exp[0] = first;
      exp[1] = !err && arm && ((ph / d2) < hi);
      exp[2] = !err && arm && first && (ph == 0);
      exp[3] = !err && arm && first && (ph == slot);
      exp[4] = err;
      act = {cfg_err, smp_strobe, cko_rise, cko_level, core_ce};
      for (int i = 0; i < 5; i++) begin
        if (act[i] != exp[i]) begin
          if (mis[i] == 0) begin fa[i] = int'(act[i]); fe[i] = int'(exp[i]); end
          mis[i]++;
        end
      end
      if (cko_rise) begin
        nrise++;
        if (first_rise < 0) first_rise = t;
        else if (second_rise < 0) second_rise = t;
      end
      if (smp_strobe) begin
        nstb++;
        if (first_stb < 0) first_stb = t;
      end
      @(negedge clk);
    end
    for (int i = 0; i < 5; i++)
      check(mis[i] == 0, {sig_tag(i), " per-cycle ", name}, fa[i], fe[i]);
    if (!err) begin
      check(first_rise == per * d1, {"R5 first rise ", name}, first_rise, per * d1);
      check(second_rise - first_rise == per * d1, {"R3 period ", name},
            second_rise - first_rise, per * d1);
      check(first_stb == (per + slot) * d1, {"R8 first strobe ", name},
            first_stb, (per + slot) * d1);
    end else begin
      check(nrise + nstb == 0, {"R9 no edges under error ", name}, nrise + nstb, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check({core_ce, cko_level, cko_rise, smp_strobe, cfg_err} == 5'b0, "R1 reset state",
          int'({core_ce, cko_level, cko_rise, smp_strobe, cfg_err}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    t_idle("after reset");
    t_sweep(0, 0, 3, 3, "ratio1 N3 zero offset");
    t_sweep(1, 2, 4, 0, "div2x3 N4 early3");
    t_sweep(3, 1, 2, 7, "div4x2 N2 late4");
    t_sweep(0, 0, 1, 7, "short period late wrap");
    t_sweep(0, 0, 1, 0, "short period early wrap");
    t_sweep(2, 3, 5, 2, "div3x4 N5 early1");
    t_sweep(2, 0, 0, 4, "forbidden N");
    t_idle("after run");
    t_sweep(1, 0, 6, 5, "restart N6 late2");
    t_idle("final");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule